// File: doc/BRIEF.md
# Maskable Interrupt Status Aggregator

This block keeps the interrupt state for a group of serial buses. Each bus owns a 15-bit status register, a 15-bit enable register and one bit in a shared summary register. Single-cycle event pulses from the command sequencers set status bits. Software clears status bits by writing ones. The single interrupt output is high whenever any summary bit is set.

An event cycle is called a post. A post masks the whole status word with the enable register. Bits that are not enabled are dropped at that moment, not only hidden from the interrupt. A summary bit is set only by a post that leaves a nonzero status. It is cleared only by a status write that leaves the status at zero, or by a per-bus clear. Software can clear the receive-done bit while that bus's sequencer still reports a receive command pending. In that case the block sends a one-cycle re-launch request back to the sequencer and evaluates the bus's interrupt again.

Register access uses a plain valid/write/address/data port. There is no back-pressure: every access completes in the cycle it is presented. Writes take effect at the next clock edge. Read data is a combinational function of the address and the current registers.

Top module: `irq_status_agg`

## Requirements
- R1: The enable register stores only write-data bits 14:0. A read returns those bits, with bits 31:15 reading zero.
- R2: A status write clears every status bit in 14:0 whose write-data bit is one. Write-data bits at positions 15 and above have no effect, and a zero bit leaves its status bit unchanged.
- R3: A post is a cycle with any event bit high for that bus, or a re-launch (R8). After a post, status equals (status after that cycle's clear, OR the event bits) AND the enable value held before that cycle.
- R4: A post whose result is nonzero sets the bus's summary bit. A post whose result is zero leaves the summary bit unchanged.
- R5: A status write that leaves the status at zero clears that bus's summary bit, even when the status was already zero.
- R6: The output `irq` is the OR of all summary bits.
- R7: When an event sets a bit in the same cycle that software clears it, the bit stays set, provided it is enabled.
- R8: Receive-done is status bit 2. A re-launch happens when bit 2 is set, a status write has data bit 2 at one, and that bus's `rx_pending` is high. The bus's `rx_relaunch` then pulses for one cycle, starting the cycle after the write, and the write counts as a post.
- R9: The summary register is read-only. Writing to it changes no register.
- R10: `bus_clr[b]` clears the enable, the status and the summary bit of bus b only. Reset clears all buses.
- R11: Address bits 1:0 select the register: 0 for enable, 1 for status, 2 for summary, 3 for nothing (reads zero). The upper address bits give the bus index. The summary register reads the same at every bus index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_valid | input | 1 | Register access this cycle |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | {bus index, register select} |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| ev_set | input | NBUS*15 | Event pulses; bus b occupies bits b*15 +: 15 |
| rx_pending | input | NBUS | A receive command is still pending on the bus |
| bus_clr | input | NBUS | Synchronous per-bus clear |
| rx_relaunch | output | NBUS | One-cycle receive re-launch request |
| irq | output | 1 | Shared interrupt line |

## Verification
The bench builds the block with its defaults: four buses and 15 status bits, which gives a 4-bit address. With four buses the bench can show that buses do not affect each other, and that the shared line is the OR of the summary bits. On every bus it sweeps all 128 combinations of the seven low event bits against four enable masks, and computes the expected status and summary arithmetically. Directed cycles cover the narrower corners: an event and a clear on the same bit in one cycle, a post that masks the status to zero while the summary stays set, and a receive-done clear with and without a pending receive.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int STAT_BITS   = 15;
  localparam int WORD_BITS   = 32;
  localparam int RX_DONE_POS = 2;

  typedef enum logic [1:0] {
    SEL_EN   = 2'd0,
    SEL_STAT = 2'd1,
    SEL_SUM  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import irq_agg_pkg::*;
#(
  parameter int NBUS   = 4,
  parameter int BIDX_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_valid,
  input  logic              reg_write,
  input  logic [BIDX_W-1:0] bus_idx,
  input  reg_sel_e          sel,
  output logic [NBUS-1:0]   en_wr,
  output logic [NBUS-1:0]   st_wr
);
  logic wr_go;
  assign wr_go = reg_valid && reg_write;

  for (genvar b = 0; b < NBUS; b++) begin : g_dec
    assign en_wr[b] = wr_go && (sel == SEL_EN)   && (bus_idx == BIDX_W'(b));
    assign st_wr[b] = wr_go && (sel == SEL_STAT) && (bus_idx == BIDX_W'(b));
  end

  // R11: one access reaches at most one register
  a_r11_single_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({en_wr, st_wr}));

  // R9: a summary-select write reaches no per-bus register
  a_r9_sum_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && sel == SEL_SUM) |-> (en_wr == '0 && st_wr == '0));
endmodule

// File: rtl/irq_bus_slice.sv
module irq_bus_slice
  import irq_agg_pkg::*;
#(
  parameter int STAT_W = STAT_BITS,
  parameter int DATA_W = WORD_BITS,
  parameter int RX_BIT = RX_DONE_POS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_wr,
  input  logic              st_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [STAT_W-1:0] ev_set,
  input  logic              rx_pending,
  input  logic              bus_clr,
  output logic [STAT_W-1:0] enable_q,
  output logic [STAT_W-1:0] status_q,
  output logic              summ_q,
  output logic              relaunch_q
);
  logic [STAT_W-1:0] clr_bits, merged, status_d;
  logic              relaunch_now, post, summ_d;

  assign clr_bits     = st_wr ? wdata[STAT_W-1:0] : '0;
  assign relaunch_now = st_wr && status_q[RX_BIT] && wdata[RX_BIT] && rx_pending;
  assign post         = (|ev_set) || relaunch_now;
  assign merged       = (status_q & ~clr_bits) | ev_set;
  assign status_d     = post ? (merged & enable_q) : merged;

  always_comb begin
    summ_d = summ_q;
    if (post && (|status_d))            summ_d = 1'b1;
    else if (st_wr && status_d == '0)   summ_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q   <= '0;
      status_q   <= '0;
      summ_q     <= 1'b0;
      relaunch_q <= 1'b0;
    end else if (bus_clr) begin
      enable_q   <= '0;
      status_q   <= '0;
      summ_q     <= 1'b0;
      relaunch_q <= 1'b0;
    end else begin
      if (en_wr) enable_q <= wdata[STAT_W-1:0];
      status_q   <= status_d;
      summ_q     <= summ_d;
      relaunch_q <= relaunch_now;
    end
  end

  // R3: after a post no status bit lies outside the prior enable mask
  a_r3_masked_after_post: assert property (@(posedge clk) disable iff (!rst_n)
    post |=> ((status_q & ~$past(enable_q)) == '0));

  // R7: an enabled event bit is present after its cycle, whatever the clear
  a_r7_event_kept: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(ev_set & enable_q)) && !bus_clr) |=>
      ((status_q & $past(ev_set & enable_q)) == $past(ev_set & enable_q)));

  // R5: a status write never leaves the summary set over a zero status
  a_r5_zero_drops_summary: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && !bus_clr) |=> (status_q != '0 || !summ_q));

  // R4: the summary bit only rises after a post
  a_r4_summary_rises_on_post: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(summ_q) |-> $past(post));

  // R8: a re-launch request needs a pending receive and a status write
  a_r8_relaunch_cause: assert property (@(posedge clk) disable iff (!rst_n)
    relaunch_q |-> $past(rx_pending && st_wr));

  // R10: a bus clear empties the slice
  a_r10_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    bus_clr |=> (enable_q == '0 && status_q == '0 && !summ_q));
endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
  import irq_agg_pkg::*;
#(
  parameter int NBUS   = 4,
  parameter int STAT_W = STAT_BITS,
  parameter int DATA_W = WORD_BITS,
  parameter int BIDX_W = 2
) (
  input  logic [BIDX_W-1:0]             bus_idx,
  input  reg_sel_e                      sel,
  input  logic [NBUS-1:0][STAT_W-1:0]   enable_all,
  input  logic [NBUS-1:0][STAT_W-1:0]   status_all,
  input  logic [NBUS-1:0]               summ,
  output logic [DATA_W-1:0]             rdata
);
  always_comb begin
    rdata = '0;
    unique case (sel)
      SEL_EN: begin
        for (int b = 0; b < NBUS; b++)
          if (bus_idx == BIDX_W'(b)) rdata[STAT_W-1:0] = enable_all[b];
      end
      SEL_STAT: begin
        for (int b = 0; b < NBUS; b++)
          if (bus_idx == BIDX_W'(b)) rdata[STAT_W-1:0] = status_all[b];
      end
      SEL_SUM:  rdata[NBUS-1:0] = summ;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_status_agg.sv
module irq_status_agg
  import irq_agg_pkg::*;
#(
  parameter int NBUS   = 4,
  parameter int STAT_W = STAT_BITS,
  parameter int DATA_W = WORD_BITS,
  localparam int BIDX_W = (NBUS > 1) ? $clog2(NBUS) : 1,
  localparam int ADDR_W = BIDX_W + 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_valid,
  input  logic                   reg_write,
  input  logic [ADDR_W-1:0]      reg_addr,
  input  logic [DATA_W-1:0]      reg_wdata,
  output logic [DATA_W-1:0]      reg_rdata,
  input  logic [NBUS*STAT_W-1:0] ev_set,
  input  logic [NBUS-1:0]        rx_pending,
  input  logic [NBUS-1:0]        bus_clr,
  output logic [NBUS-1:0]        rx_relaunch,
  output logic                   irq
);
  reg_sel_e                    sel;
  logic [BIDX_W-1:0]           bus_idx;
  logic [NBUS-1:0]             en_wr, st_wr, summ;
  logic [NBUS-1:0][STAT_W-1:0] ev_vec, enable_all, status_all;

  assign sel     = reg_sel_e'(reg_addr[1:0]);
  assign bus_idx = reg_addr[ADDR_W-1:2];
  assign ev_vec  = ev_set;

  irq_reg_decode #(.NBUS(NBUS), .BIDX_W(BIDX_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
    .bus_idx(bus_idx), .sel(sel), .en_wr(en_wr), .st_wr(st_wr)
  );

  for (genvar b = 0; b < NBUS; b++) begin : g_bus
    irq_bus_slice #(.STAT_W(STAT_W), .DATA_W(DATA_W)) u_slice (
      .clk(clk), .rst_n(rst_n), .en_wr(en_wr[b]), .st_wr(st_wr[b]),
      .wdata(reg_wdata), .ev_set(ev_vec[b]), .rx_pending(rx_pending[b]),
      .bus_clr(bus_clr[b]), .enable_q(enable_all[b]), .status_q(status_all[b]),
      .summ_q(summ[b]), .relaunch_q(rx_relaunch[b])
    );
  end

  irq_read_mux #(.NBUS(NBUS), .STAT_W(STAT_W), .DATA_W(DATA_W), .BIDX_W(BIDX_W)) u_rd (
    .bus_idx(bus_idx), .sel(sel), .enable_all(enable_all), .status_all(status_all),
    .summ(summ), .rdata(reg_rdata)
  );

  assign irq = |summ;

  // R6: the line cannot rise without some bus posting in the prior cycle
  a_r6_irq_rise_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past((|ev_set) || (|st_wr)));
endmodule

// File: tb/test_irq_status_agg.sv
module test_irq_status_agg;
  localparam int NB = 4;
  localparam int SW = 15;
  localparam int AW = 4;
  localparam logic [1:0] S_EN = 2'd0, S_ST = 2'd1, S_SUM = 2'd2, S_NONE = 2'd3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_valid = 1'b0, reg_write = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [NB*SW-1:0] ev_set = '0;
  logic [NB-1:0] rx_pending = '0, bus_clr = '0, rx_relaunch;
  logic irq;

  int checks = 0, errors = 0;
  logic [SW-1:0] m_en [NB];
  logic [SW-1:0] m_st [NB];
  logic          m_sum [NB];

  irq_status_agg i_irq_status_agg (
    .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ev_set(ev_set), .rx_pending(rx_pending), .bus_clr(bus_clr),
    .rx_relaunch(rx_relaunch), .irq(irq)
  );

  always #5 clk = ~clk;

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R0 watchdog actual timeout expected completion");
    finish_run();
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0; ev_set = '0; bus_clr = '0;
  endtask

  task automatic drive_wr(input int b, input logic [1:0] sel, input logic [31:0] d);
    reg_valid = 1'b1; reg_write = 1'b1;
    reg_addr = {b[1:0], sel}; reg_wdata = d;
  endtask

  task automatic rd(input int b, input logic [1:0] sel, output logic [31:0] d);
    reg_addr = {b[1:0], sel};
    #1 d = reg_rdata;
  endtask

  function automatic logic any_sum();
    logic r = 1'b0;
    for (int b = 0; b < NB; b++) r |= m_sum[b];
    return r;
  endfunction

  // bench model updates, from the requirements
  task automatic set_en(input int b, input logic [31:0] d);
    drive_wr(b, S_EN, d); tick();
    m_en[b] = d[SW-1:0];
  endtask

  task automatic clr_st(input int b, input logic [31:0] d);
    drive_wr(b, S_ST, d); tick();
    m_st[b] = m_st[b] & ~d[SW-1:0];
    if (m_st[b] == '0) m_sum[b] = 1'b0;
  endtask

  task automatic post(input int b, input logic [SW-1:0] bits);
    ev_set[b*SW +: SW] = bits; tick();
    m_st[b] = (m_st[b] | bits) & m_en[b];
    if (m_st[b] != '0) m_sum[b] = 1'b1;
  endtask

  task automatic chk_bus(input int b, input string tag);
    logic [31:0] d;
    rd(b, S_EN, d); chk({tag, " enable"}, d, {17'd0, m_en[b]});
    rd(b, S_ST, d); chk({tag, " status"}, d, {17'd0, m_st[b]});
    rd(b, S_SUM, d); chk({tag, " summary"}, d[b], m_sum[b]);
    chk({tag, " irq R6"}, irq, any_sum());
  endtask

  initial begin
    logic [31:0] d;
    for (int b = 0; b < NB; b++) begin m_en[b] = '0; m_st[b] = '0; m_sum[b] = 1'b0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    for (int b = 0; b < NB; b++) chk_bus(b, "R10 reset");
    rd(0, S_SUM, d); chk("R10 reset summary word", d, 32'd0);

    // R1 enable width
    set_en(1, 32'hFFFF_FFFF);
    rd(1, S_EN, d); chk("R1 enable low 15 bits", d, 32'h0000_7FFF);
    set_en(1, 32'h0);

    // R3 R4 R5 R6 exhaustive sweep of low event bits against masks
    for (int b = 0; b < NB; b++) begin
      for (int m = 0; m < 4; m++) begin
        logic [SW-1:0] mask;
        mask = (m == 0) ? 15'h7FFF : (m == 1) ? 15'h0055 : (m == 2) ? 15'h0000 : 15'h002A;
        set_en(b, {17'd0, mask});
        for (int e = 0; e < 128; e++) begin
          clr_st(b, 32'h7FFF);
          post(b, SW'(e));
          rd(b, S_ST, d);  chk("R3 sweep status", d, {17'd0, SW'(e) & mask});
          rd(b, S_SUM, d); chk("R4 sweep summary", d[b], ((SW'(e) & mask) != '0));
          chk("R6 sweep irq", irq, any_sum());
        end
        clr_st(b, 32'h7FFF);
        chk_bus(b, "R5 sweep cleared");
      end
      set_en(b, 32'h0);
    end

    // R3 raising drops bits no longer enabled
    set_en(0, 32'h7FFF);
    post(0, 15'h0033);
    set_en(0, 32'h0011);
    post(0, 15'h0100);
    chk_bus(0, "R3 mask drops old bits");

    // R2 upper write bits ignored, partial clear keeps summary
    set_en(0, 32'h7FFF);
    post(0, 15'h0003);
    clr_st(0, 32'hFFFF_8000);
    chk_bus(0, "R2 upper bits ignored");
    clr_st(0, 32'h0000_0001);
    chk_bus(0, "R2 partial clear");
    clr_st(0, 32'h0000_0002);
    chk_bus(0, "R5 last bit clears summary");

    // R9 summary writes ignored
    post(0, 15'h0010);
    drive_wr(0, S_SUM, 32'h0); tick();
    chk_bus(0, "R9 summary write zero");
    drive_wr(2, S_SUM, 32'hFFFF_FFFF); tick();
    chk_bus(2, "R9 summary write ones");
    // R11 summary readable at any index, select 3 reads zero
    rd(3, S_SUM, d); chk("R11 summary alias", d, 32'h1);
    rd(0, S_NONE, d); chk("R11 select 3 reads zero", d, 32'h0);
    clr_st(0, 32'h7FFF);

    // R7 event beats a same-cycle clear
    set_en(1, 32'h7FFF);
    post(1, 15'h0001);
    ev_set[1*SW +: SW] = 15'h0001; drive_wr(1, S_ST, 32'h1); tick();
    chk_bus(1, "R7 same bit set and clear");
    ev_set[1*SW +: SW] = 15'h0002; drive_wr(1, S_ST, 32'h1); tick();
    m_st[1] = 15'h0002;
    chk_bus(1, "R7 set one clear another");
    clr_st(1, 32'h7FFF);

    // R4 post masked to zero leaves summary set; R5 empty write clears it
    set_en(3, 32'h7FFF);
    post(3, 15'h0008);
    set_en(3, 32'h0);
    post(3, 15'h0010);
    chk_bus(3, "R4 zero post keeps summary");
    clr_st(3, 32'h0);
    chk_bus(3, "R5 empty write on zero status");

    // R8 re-launch with pending receive (bit 2 = receive done)
    set_en(2, 32'h7FFF);
    post(2, 15'h0005);
    set_en(2, 32'h0004);
    rx_pending[2] = 1'b1;
    drive_wr(2, S_ST, 32'h4); tick();
    m_st[2] = 15'h0000; m_sum[2] = 1'b0;
    chk("R8 relaunch pulse", rx_relaunch, 4'b0100);
    chk_bus(2, "R8 relaunch re-evaluates");
    tick();
    chk("R8 relaunch one cycle", rx_relaunch, 4'b0000);
    // without a pending receive: no relaunch, no masking
    set_en(2, 32'h7FFF);
    post(2, 15'h0005);
    set_en(2, 32'h0004);
    rx_pending[2] = 1'b0;
    clr_st(2, 32'h4);
    chk("R8 no relaunch without pending", rx_relaunch, 4'b0000);
    chk_bus(2, "R8 plain clear");
    // receive-done already clear: no relaunch
    rx_pending[2] = 1'b1;
    clr_st(2, 32'h4);
    chk("R8 no relaunch when bit clear", rx_relaunch, 4'b0000);
    rx_pending[2] = 1'b0;
    clr_st(2, 32'h7FFF);

    // R10 per-bus clear touches one bus only; R6 OR across buses
    set_en(0, 32'h7FFF); post(0, 15'h0040);
    set_en(1, 32'h7FFF); post(1, 15'h0020);
    bus_clr[0] = 1'b1; tick();
    m_en[0] = '0; m_st[0] = '0; m_sum[0] = 1'b0;
    chk_bus(0, "R10 bus clear target");
    chk_bus(1, "R10 bus clear neighbour");
    clr_st(1, 32'h7FFF);
    chk("R6 irq low when all clear", irq, 1'b0);

    finish_run();
  end
endmodule